// File: doc/BRIEF.md
# Flash Ready Poller with Program Verify and Retry

This block supervises a single byte program on a parallel NOR flash device. After the block asks the command issuer to program a byte, it polls the device status until the embedded program operation has finished. It reads the byte back and compares it with the data it wanted. If the two differ, it asks for the whole program sequence again, up to a bounded number of times. The command issuer and the flash array sit outside the block. The block only raises a program request carrying address and data, and reads the device through a simple request/response read port.

Two completion tests are available. The toggle test watches status bit 6 and treats the device as ready once two back-to-back reads agree on it. The data test watches bit 7 and treats the device as ready once it matches bit 7 of the byte being written. For slow devices, a minimum wait can be placed between toggle reads. This wait is counted in clock cycles derived from a cycles-per-microsecond parameter. An iteration limit bounds every polling loop. A lower warning threshold flags loops that ran unusually long. Each operation ends with exactly one one-cycle verdict: done, fail or timeout.

Top module: `nor_prog_supervisor`

## Requirements
- R1: While reset is held and after it, busy, done, fail, timeout, prog_req and rd_req are all low until a start is accepted.
- R2: A start whose data is 0xFF produces a done pulse in the cycle after the start. It raises no prog_req and no rd_req, and busy stays low.
- R3: Any other accepted start raises prog_req for one cycle with the start address and data. Every following read uses that address as rd_addr.
- R4: With poll_mode = 0 (toggle test), the first read after a program request is only a reference. Readiness is declared on the first later read whose bit 6 equals bit 6 of the read just before it.
- R5: With poll_mode = 1 (data test), readiness is declared on the first read whose bit 7 equals bit 7 of the data being programmed.
- R6: With poll_mode = 0 and slow_poll = 1, at least CYCLES_PER_US*SLOW_DELAY_US clock cycles pass between the response of one status read and the request of the next status read. With slow_poll = 0, the next request follows in the cycle after the response. The data test never waits.
- R7: If ITER_LIMIT comparing reads pass within one program attempt without readiness, the block pulses timeout, performs no verify read and returns to idle.
- R8: slow_warn goes high once more than WARN_LIMIT comparing reads occur within one attempt. It stays high until the next accepted start clears it.
- R9: After readiness, the block reads the target byte once. If it equals the data, the block pulses done.
- R10: On a verify mismatch, the block raises prog_req again and repeats polling and verify, up to MAX_RETRIES reissues. A mismatch after the last reissue pulses fail. At most MAX_RETRIES+1 program requests are made per operation.
- R11: A start while busy is ignored. Address, data and mode of the running operation do not change, and no extra verdict follows.
- R12: done, fail and timeout are one-cycle pulses, never more than one at a time, and busy is low in the cycle a verdict is high.
- R13: rd_req is a one-cycle pulse. No new read is requested until rd_valid has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| start_addr | input | ADDR_W | Target byte address |
| start_data | input | 8 | Byte to program |
| poll_mode | input | 1 | 0 = toggle test on bit 6, 1 = data test on bit 7 |
| slow_poll | input | 1 | 1 = insert the slow wait between toggle reads |
| prog_req | output | 1 | One-cycle request to issue the program sequence |
| prog_addr | output | ADDR_W | Address for the program sequence |
| prog_data | output | 8 | Data for the program sequence |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 8 | Read response data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: byte verified (or skipped as 0xFF) |
| fail | output | 1 | Pulse: verify still wrong after all reissues |
| timeout | output | 1 | Pulse: polling loop hit the iteration limit |
| slow_warn | output | 1 | Polling ran past the warning threshold in this operation |

## Verification
The hardest states to reach from the ports are the last reissue before fail and the warning threshold. The first needs a device that stores wrong data for a chosen number of program attempts and then behaves. The second needs a device that stays busy for a chosen number of reads. The bench's device model therefore takes a per-operation count of corrupted stores and a count of busy reads. During busy reads it toggles bit 6 and inverts bit 7. This lets directed cases sit exactly at MAX_RETRIES and one past it, and lets one case cross WARN_LIMIT without timing out. A premature readiness decision shows up as an extra program request, because the verify read would then return a busy status value instead of the stored byte.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

    // Status bit positions returned by the flash device during an embedded operation
    localparam int TOGGLE_BIT = 6;
    localparam int DPOLL_BIT  = 7;

    // Erased value: programming it would change nothing
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_DATA   = 1'b1
    } poll_mode_e;

    typedef enum logic [2:0] {
        SUP_IDLE,
        SUP_ISSUE,
        SUP_POLL,
        SUP_VREQ,
        SUP_VWAIT
    } sup_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_REQ,
        ENG_WAIT,
        ENG_GAP
    } eng_state_e;

    typedef struct packed {
        logic [7:0] data;
        poll_mode_e mode;
        logic       slow;
    } job_t;

    // stat[1] is status bit 7, stat[0] is status bit 6
    function automatic logic status_settled(poll_mode_e m, logic [1:0] stat,
                                            logic prev6, logic want7);
        if (m == MODE_TOGGLE)
            return stat[0] == prev6;
        return stat[1] == want7;
    endfunction

endpackage

// File: rtl/nor_gap_timer.sv
module nor_gap_timer #(
    parameter int GAP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic idle
);
    localparam int CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] GAP_V = CW'(GAP_CYCLES);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (load)
            left_q <= GAP_V;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign idle = (left_q == '0);

    // a freshly loaded wait must hold the poller back for at least one cycle
    assert_gap_armed_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> !idle);

endmodule

// File: rtl/nor_poll_engine.sv
module nor_poll_engine
    import nor_poll_pkg::*;
#(
    parameter int ITER_LIMIT = 268435455,
    parameter int WARN_LIMIT = 1048576,
    parameter int GAP_CYCLES = 2000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       new_op,
    input  poll_mode_e mode,
    input  logic       slow,
    input  logic       want_msb,
    input  logic       rd_valid,
    input  logic [1:0] stat,
    output logic       rd_req,
    output logic       ready,
    output logic       expired,
    output logic       warn
);
    localparam int CW = $clog2(ITER_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(ITER_LIMIT);
    localparam logic [CW-1:0] WARN_V  = CW'(WARN_LIMIT);

    eng_state_e    st_q;
    logic [CW-1:0] n_q;
    logic [CW-1:0] n_nx;
    logic          ref_q;
    logic          have_ref_q;
    logic          first_sample;
    logic          settled;
    logic          to_gap;
    logic          gap_idle;

    assign n_nx         = n_q + 1'b1;
    assign first_sample = (mode == MODE_TOGGLE) && !have_ref_q;
    assign settled      = status_settled(mode, stat, ref_q, want_msb);

    // the slow wait sits only between toggle reads that lead to another read
    assign to_gap = (st_q == ENG_WAIT) && rd_valid && slow && (mode == MODE_TOGGLE) &&
                    (first_sample || (!settled && (n_nx != LIMIT_V)));

    nor_gap_timer #(
        .GAP_CYCLES(GAP_CYCLES)
    ) u_gap (
        .clk (clk),
        .rst (rst),
        .load(to_gap),
        .idle(gap_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ENG_IDLE;
            n_q        <= '0;
            ref_q      <= 1'b0;
            have_ref_q <= 1'b0;
            ready      <= 1'b0;
            expired    <= 1'b0;
            warn       <= 1'b0;
        end else begin
            ready   <= 1'b0;
            expired <= 1'b0;
            if (new_op)
                warn <= 1'b0;
            unique case (st_q)
                ENG_IDLE: begin
                    if (go) begin
                        n_q        <= '0;
                        have_ref_q <= 1'b0;
                        st_q       <= ENG_REQ;
                    end
                end
                ENG_REQ: st_q <= ENG_WAIT;
                ENG_WAIT: begin
                    if (rd_valid) begin
                        if (first_sample) begin
                            ref_q      <= stat[0];
                            have_ref_q <= 1'b1;
                            st_q       <= to_gap ? ENG_GAP : ENG_REQ;
                        end else begin
                            n_q <= n_nx;
                            if (n_nx > WARN_V)
                                warn <= 1'b1;
                            if (settled) begin
                                ready <= 1'b1;
                                st_q  <= ENG_IDLE;
                            end else if (n_nx == LIMIT_V) begin
                                expired <= 1'b1;
                                st_q    <= ENG_IDLE;
                            end else begin
                                ref_q <= stat[0];
                                st_q  <= to_gap ? ENG_GAP : ENG_REQ;
                            end
                        end
                    end
                end
                ENG_GAP: begin
                    if (gap_idle)
                        st_q <= ENG_REQ;
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign rd_req = (st_q == ENG_REQ);

    assert_single_verdict_R7: assert property (@(posedge clk) disable iff (rst)
        !(ready && expired));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        n_q <= LIMIT_V);

    assert_expire_at_limit_R7: assert property (@(posedge clk) disable iff (rst)
        expired |-> (n_q == LIMIT_V));

    assert_warn_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(warn) |-> $past(new_op));

endmodule

// File: rtl/nor_prog_supervisor.sv
module nor_prog_supervisor
    import nor_poll_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int CYCLES_PER_US = 250,
    parameter int SLOW_DELAY_US = 8000,
    parameter int ITER_LIMIT    = 268435455,
    parameter int WARN_LIMIT    = 1048576,
    parameter int MAX_RETRIES   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic              poll_mode,
    input  logic              slow_poll,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              timeout,
    output logic              slow_warn
);
    localparam int GAP_CYCLES = CYCLES_PER_US * SLOW_DELAY_US;
    localparam int RW         = $clog2(MAX_RETRIES + 2);
    localparam logic [RW-1:0] RETRY_V = RW'(MAX_RETRIES);

    sup_state_e        st_q;
    job_t              job_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RW-1:0]     tries_q;
    logic              done_q;
    logic              fail_q;
    logic              tmo_q;
    logic              accept;
    logic              eng_go;
    logic              eng_rd_req;
    logic              eng_ready;
    logic              eng_expired;

    assign accept = (st_q == SUP_IDLE) && start;
    assign eng_go = (st_q == SUP_ISSUE);

    nor_poll_engine #(
        .ITER_LIMIT(ITER_LIMIT),
        .WARN_LIMIT(WARN_LIMIT),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .go      (eng_go),
        .new_op  (accept),
        .mode    (job_q.mode),
        .slow    (job_q.slow),
        .want_msb(job_q.data[DPOLL_BIT]),
        .rd_valid(rd_valid),
        .stat    (rd_data[DPOLL_BIT:TOGGLE_BIT]),
        .rd_req  (eng_rd_req),
        .ready   (eng_ready),
        .expired (eng_expired),
        .warn    (slow_warn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SUP_IDLE;
            job_q   <= '0;
            addr_q  <= '0;
            tries_q <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
            unique case (st_q)
                SUP_IDLE: begin
                    if (start) begin
                        addr_q     <= start_addr;
                        job_q.data <= start_data;
                        job_q.mode <= poll_mode_e'(poll_mode);
                        job_q.slow <= slow_poll;
                        tries_q    <= '0;
                        if (start_data == BLANK_BYTE)
                            done_q <= 1'b1;
                        else
                            st_q <= SUP_ISSUE;
                    end
                end
                SUP_ISSUE: st_q <= SUP_POLL;
                SUP_POLL: begin
                    if (eng_ready) begin
                        st_q <= SUP_VREQ;
                    end else if (eng_expired) begin
                        tmo_q <= 1'b1;
                        st_q  <= SUP_IDLE;
                    end
                end
                SUP_VREQ: st_q <= SUP_VWAIT;
                SUP_VWAIT: begin
                    if (rd_valid) begin
                        if (rd_data == job_q.data) begin
                            done_q <= 1'b1;
                            st_q   <= SUP_IDLE;
                        end else if (tries_q < RETRY_V) begin
                            tries_q <= tries_q + 1'b1;
                            st_q    <= SUP_ISSUE;
                        end else begin
                            fail_q <= 1'b1;
                            st_q   <= SUP_IDLE;
                        end
                    end
                end
                default: st_q <= SUP_IDLE;
            endcase
        end
    end

    assign prog_req  = (st_q == SUP_ISSUE);
    assign prog_addr = addr_q;
    assign prog_data = job_q.data;
    assign rd_req    = eng_rd_req | (st_q == SUP_VREQ);
    assign rd_addr   = addr_q;
    assign busy      = (st_q != SUP_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;
    assign timeout   = tmo_q;

    assert_one_verdict_R12: assert property (@(posedge clk) disable iff (rst)
        $countones({done, fail, timeout}) <= 1);

    assert_idle_on_verdict_R12: assert property (@(posedge clk) disable iff (rst)
        (done || fail || timeout) |-> !busy);

    assert_no_blank_program_R2: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> (prog_data != BLANK_BYTE));

    assert_read_spaced_R13: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    assert_retry_bound_R10: assert property (@(posedge clk) disable iff (rst)
        tries_q <= RETRY_V);

    assert_job_held_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(prog_addr) && $stable(prog_data)));

endmodule

// File: tb/nor_prog_supervisor_bench.sv
`timescale 1ns/1ps
module nor_prog_supervisor_bench;
    localparam int AW    = 8;
    localparam int CPU   = 2;
    localparam int SDU   = 4;
    localparam int GAP   = CPU * SDU;
    localparam int ITERS = 40;
    localparam int WARNS = 10;
    localparam int MAXR  = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = '0;
    logic          poll_mode = 1'b0;
    logic          slow_poll = 1'b0;
    logic          prog_req;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          busy, done, fail, timeout, slow_warn;

    nor_prog_supervisor #(
        .ADDR_W(AW), .CYCLES_PER_US(CPU), .SLOW_DELAY_US(SDU),
        .ITER_LIMIT(ITERS), .WARN_LIMIT(WARNS), .MAX_RETRIES(MAXR)
    ) u_nor_prog_supervisor (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_data(start_data), .poll_mode(poll_mode), .slow_poll(slow_poll),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .fail(fail), .timeout(timeout), .slow_warn(slow_warn)
    );

    // ---------------- device model (settings written only by the stimulus) ----
    int            busy_cfg = 1;
    int            faults_cfg = 0;
    bit            stuck_cfg = 0;
    bit            gap_cfg = 0;
    int            op_base = 0;
    logic [AW-1:0] exp_addr = '0;

    logic [7:0] mem [16];
    int   busy_left = 0;
    int   prog_cnt = 0;
    int   addr_err = 0;
    int   plain_reads = 0;
    int   all_reads = 0;
    int   overlap_err = 0;
    int   multi_verdict = 0;
    int   verdict_cnt = 0;
    int   cyc = 0;
    int   last_valid_cyc = 0;
    int   min_gap_slow = 1000000;
    int   min_gap_fast = 1000000;
    logic tog = 1'b0;
    logic [7:0] last_prog = '0;
    logic pend_v = 1'b0;
    logic pend_busy = 1'b0;
    logic resp_busy = 1'b0;
    logic prev_busy = 1'b0;
    logic outstanding = 1'b0;
    logic [7:0] pend_d = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
        end
        if (prog_req) begin
            prog_cnt  <= prog_cnt + 1;
            busy_left <= busy_cfg;
            last_prog <= prog_data;
            if (prog_addr != exp_addr) addr_err <= addr_err + 1;
            if ((prog_cnt - op_base) < faults_cfg)
                mem[prog_addr[3:0]] <= prog_data ^ 8'h01;
            else
                mem[prog_addr[3:0]] <= prog_data;
        end
        pend_v <= rd_req;
        if (rd_req) begin
            all_reads <= all_reads + 1;
            if (outstanding) overlap_err <= overlap_err + 1;
            if (prev_busy) begin
                if (gap_cfg && (cyc - last_valid_cyc) < min_gap_slow) min_gap_slow <= cyc - last_valid_cyc;
                if (!gap_cfg && (cyc - last_valid_cyc) < min_gap_fast) min_gap_fast <= cyc - last_valid_cyc;
            end
            if (stuck_cfg || busy_left > 0) begin
                pend_d    <= {~last_prog[7], tog, 6'b010101};
                tog       <= ~tog;
                pend_busy <= 1'b1;
                if (!stuck_cfg) busy_left <= busy_left - 1;
            end else begin
                pend_d      <= mem[rd_addr[3:0]];
                pend_busy   <= 1'b0;
                plain_reads <= plain_reads + 1;
            end
        end
        outstanding <= rd_req ? 1'b1 : (rd_valid ? 1'b0 : outstanding);
        if (rd_valid) begin
            last_valid_cyc <= cyc;
            prev_busy      <= resp_busy;
        end
        rd_valid  <= pend_v;
        rd_data   <= pend_d;
        resp_busy <= pend_busy;
        if ((int'(done) + int'(fail) + int'(timeout)) > 1) multi_verdict <= multi_verdict + 1;
        if (done || fail || timeout) verdict_cnt <= verdict_cnt + 1;
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // 0 done, 1 fail, 2 timeout
    function automatic void predict(input logic [7:0] d, input int faults, input bit stuck,
                                    output int res, output int issues);
        if (d == 8'hFF) begin res = 0; issues = 0; end
        else if (stuck) begin res = 2; issues = 1; end
        else if (faults <= MAXR) begin res = 0; issues = faults + 1; end
        else begin res = 1; issues = MAXR + 1; end
    endfunction

    int r_res, r_iss, r_busy_at, r_warn, r_plain;

    task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input bit mode,
                          input bit slow, input int b, input int faults, input bit stuck,
                          input bit inject);
        int base_plain;
        @(negedge clk);
        busy_cfg = b; faults_cfg = faults; stuck_cfg = stuck; exp_addr = a;
        gap_cfg = slow && !mode; op_base = prog_cnt; base_plain = plain_reads;
        start = 1'b1; start_addr = a; start_data = d; poll_mode = mode; slow_poll = slow;
        @(negedge clk);
        start = 1'b0;
        r_res = 3;
        for (int i = 0; i < 6000; i++) begin
            if (inject && i == 3) begin
                start = 1'b1; start_addr = a ^ 8'h05; start_data = ~d; poll_mode = ~mode;
            end
            if (inject && i == 4) start = 1'b0;
            if (done || fail || timeout) begin
                r_res = done ? 0 : (fail ? 1 : 2);
                r_busy_at = busy;
                r_warn = slow_warn;
                break;
            end
            @(negedge clk);
        end
        r_iss = prog_cnt - op_base;
        r_plain = plain_reads - base_plain;
        @(negedge clk);
        check("R12 verdict lasts one cycle", int'(done || fail || timeout), 0);
    endtask

    task automatic run_and_check(input string tag, input logic [AW-1:0] a, input logic [7:0] d,
                                 input bit mode, input bit slow, input int b, input int faults,
                                 input bit stuck, input bit warn_exp);
        int e_res, e_iss;
        predict(d, faults, stuck, e_res, e_iss);
        run_op(a, d, mode, slow, b, faults, stuck, 1'b0);
        check({tag, " verdict"}, r_res, e_res);
        check({tag, " program requests (R10)"}, r_iss, e_iss);
        check("R12 busy low at verdict", r_busy_at, 0);
        check({tag, " warning (R8)"}, r_warn, int'(warn_exp));
        if (e_res == 0 && d != 8'hFF)
            check({tag, " stored byte (R9)"}, int'(mem[a[3:0]]), int'(d));
    endtask

    initial begin
        void'($urandom(32'd20240607));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 verdicts in reset", int'(done) + int'(fail) + int'(timeout), 0);
        check("R1 requests in reset", int'(prog_req) + int'(rd_req), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", int'(busy) + int'(prog_req) + int'(rd_req) + int'(done), 0);

        // R2: blank byte skipped
        run_op(8'h03, 8'hFF, 1'b0, 1'b0, 3, 0, 1'b0, 1'b0);
        check("R2 blank byte verdict", r_res, 0);
        check("R2 blank byte program requests", r_iss, 0);
        check("R2 blank byte reads", r_plain, 0);
        check("R2 busy stays low", r_busy_at, 0);

        // R3 R4 R9: toggle test, a premature decision would cost an extra program request
        run_and_check("R4 toggle fast", 8'h05, 8'h5A, 1'b0, 1'b0, 5, 0, 1'b0, 1'b0);
        check("R3 program address", addr_err, 0);
        // R5: data test
        run_and_check("R5 data fast", 8'h06, 8'h3C, 1'b1, 1'b0, 6, 0, 1'b0, 1'b0);
        run_and_check("R5 data high msb", 8'h07, 8'hC3, 1'b1, 1'b0, 2, 0, 1'b0, 1'b0);
        // R6: slow toggle spacing
        run_and_check("R6 toggle slow", 8'h08, 8'h81, 1'b0, 1'b1, 4, 0, 1'b0, 1'b0);
        check("R6 slow spacing >= wait", int'(min_gap_slow >= GAP), 1);
        check("R6 fast spacing is one cycle", min_gap_fast, 1);

        // R7: stuck device times out without verify read, R8 warning set
        run_and_check("R7 stuck toggle", 8'h09, 8'h11, 1'b0, 1'b0, 1, 0, 1'b1, 1'b1);
        check("R7 no verify read", r_plain, 0);
        repeat (5) @(negedge clk);
        check("R8 warning held after verdict", int'(slow_warn), 1);
        run_and_check("R8 cleared by new start", 8'h0A, 8'h22, 1'b0, 1'b0, 3, 0, 1'b0, 1'b0);
        run_and_check("R8 long busy", 8'h0B, 8'h44, 1'b0, 1'b0, 20, 0, 1'b0, 1'b1);
        run_and_check("R7 stuck data", 8'h0C, 8'h66, 1'b1, 1'b0, 1, 0, 1'b1, 1'b1);

        // R10: retry edge
        run_and_check("R10 last retry passes", 8'h0D, 8'h70, 1'b0, 1'b0, 2, MAXR, 1'b0, 1'b0);
        run_and_check("R10 retries exhausted", 8'h0E, 8'h71, 1'b1, 1'b0, 2, MAXR + 1, 1'b0, 1'b0);

        // R11: start during an operation is ignored
        begin
            int vc;
            run_op(8'h0F, 8'h29, 1'b0, 1'b0, 6, 1, 1'b0, 1'b1);
            check("R11 verdict of held operation", r_res, 0);
            check("R11 program address unchanged", addr_err, 0);
            check("R11 program requests", r_iss, 2);
            check("R11 original byte stored", int'(mem[15]), 8'h29);
            vc = verdict_cnt;
            repeat (30) @(negedge clk);
            check("R11 no extra verdict", verdict_cnt - vc, 0);
            check("R11 idle afterwards", int'(busy), 0);
        end

        // constrained random mix
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            bit md, sl, st;
            int b, f;
            d  = 8'($urandom_range(0, 254));
            if ($urandom_range(0, 7) == 0) d = 8'hFF;
            md = 1'($urandom_range(0, 1));
            sl = ($urandom_range(0, 5) == 0);
            st = ($urandom_range(0, 11) == 0);
            b  = $urandom_range(1, 8);
            f  = ($urandom_range(0, 2) == 0) ? $urandom_range(0, MAXR + 1) : 0;
            run_and_check("R3 random", 8'($urandom_range(0, 15)), d, md, sl, b, f, st,
                          st && d != 8'hFF);
        end

        check("R3 program address overall", addr_err, 0);
        check("R12 simultaneous verdicts", multi_verdict, 0);
        check("R13 overlapping reads", overlap_err, 0);
        check("R6 slow spacing overall", int'(min_gap_slow >= GAP), 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog: actual no finish expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule